// File: doc/BRIEF.md
# Operand Bypass Unit for an In-Order Integer Pipeline

This block removes data hazards between back-to-back arithmetic instructions in a five-stage in-order pipeline. Results are computed in the execute stage but only reach the register file at writeback. Source registers, however, are read in decode. That leaves three cycles in which a consumer could pick up a stale value. The unit closes that window at three points, chosen by the distance between producer and consumer:

- **Distance one.** The execute-stage operand is taken from the execute/memory pipeline register.
- **Distance two.** The operand is taken from the memory/writeback pipeline register.
- **Distance three.** The register file itself is bypassed: a value being written in a cycle replaces the value read from the same register in that cycle.

The unit contains the integer register file with two read ports and one write port. The decode read ports carry the write-around path. Two independent select/multiplexer slices produce the execute-stage operands. Each slice reports its 2-bit select so the rest of the pipeline can observe which source was used.

Instruction distance is the difference of two word-aligned instruction addresses divided by four. Register zero is hardwired to zero and never acts as a forwarding source. Producers are retired in program order, so write-after-write pairs need no handling beyond preferring the younger producer.

Top module: `opnd_bypass_top`

## Requirements
- R1: After reset is released, every register reads zero on both read ports.
- R2: Register zero always reads zero, and a write to it has no effect on either read port.
- R3: A write with `wb_we_i` high to a nonzero register is stored at the clock edge and is returned by later reads of that register.
- R4: In the same cycle as a write with `wb_we_i` high and nonzero `wb_rd_i`, a read port whose address equals `wb_rd_i` returns `wb_data_i` instead of the stored value. With `wb_we_i` low, the stored value is returned.
- R5: When `exm_we_i` is high, `exm_rd_i` is nonzero and it equals an operand's source register, that operand's select is 2'b10 and its output is `exm_data_i`.
- R6: When R5 does not apply, and `mwb_we_i` is high with `mwb_rd_i` nonzero and equal to the source register, the select is 2'b01 and the output is `mwb_data_i`.
- R7: When both pipeline registers match the same source register, the execute/memory value (select 2'b10) wins.
- R8: With no qualifying match (write enable low or destination zero), the select is 2'b00 and the output is the operand value read in decode.
- R9: The two read ports and the two operand slices act independently; a match on one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_addr_a_i | input | 5 | Decode read address, port A |
| rd_addr_b_i | input | 5 | Decode read address, port B |
| rd_data_a_o | output | 32 | Decode read data with write-around, port A |
| rd_data_b_o | output | 32 | Decode read data with write-around, port B |
| wb_we_i | input | 1 | Writeback write enable |
| wb_rd_i | input | 5 | Writeback destination register |
| wb_data_i | input | 32 | Writeback data |
| ex_src_a_i | input | 5 | Execute-stage source register, operand A |
| ex_src_b_i | input | 5 | Execute-stage source register, operand B |
| ex_opnd_a_i | input | 32 | Operand A value read in decode |
| ex_opnd_b_i | input | 32 | Operand B value read in decode |
| exm_we_i | input | 1 | Execute/memory register write enable |
| exm_rd_i | input | 5 | Execute/memory destination register |
| exm_data_i | input | 32 | Execute/memory result |
| mwb_we_i | input | 1 | Memory/writeback register write enable |
| mwb_rd_i | input | 5 | Memory/writeback destination register |
| mwb_data_i | input | 32 | Memory/writeback result |
| sel_a_o | output | 2 | Operand A select (00 file, 01 mem/wb, 10 ex/mem) |
| sel_b_o | output | 2 | Operand B select |
| fwd_a_o | output | 32 | Execute-stage operand A |
| fwd_b_o | output | 32 | Execute-stage operand B |

## Verification
Apart from the register file contents, all logic is combinational. A wrong select or a broken priority therefore shows on `sel_*_o` and `fwd_*_o` in the same cycle as the offending inputs. A corrupted or missed register write only appears the next time that register is read. The bench therefore reads back each written register on the cycle after the write edge. It also checks the write-around path in the write cycle itself, so errors in storage and errors in bypass are told apart.

// File: rtl/opnd_bypass_pkg.sv
`timescale 1ns/1ps
package opnd_bypass_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/opnd_regfile.sv
`timescale 1ns/1ps
module opnd_regfile #(
  parameter int NREGS  = 32,
  parameter int DW     = 32,
  parameter int NPORTS = 2,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              wa_i,
  input  logic [DW-1:0]              wd_i,
  input  logic [NPORTS-1:0][AW-1:0]  ra_i,
  output logic [NPORTS-1:0][DW-1:0]  rd_o
);
  logic [DW-1:0] mem_q [NREGS];
  logic          wr_ok;

  assign wr_ok = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_rport
    // literal write-around instead of split-phase access
    always_comb begin
      if (ra_i[p] == '0)                rd_o[p] = '0;
      else if (wr_ok && ra_i[p] == wa_i) rd_o[p] = wd_i;
      else                               rd_o[p] = mem_q[ra_i[p]];
    end

    // R3
    rf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(wr_ok) && ra_i[p] == $past(wa_i) && !(wr_ok && wa_i == ra_i[p]))
        |-> rd_o[p] == $past(wd_i));
    // R2
    zero_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ra_i[p] == '0) |-> rd_o[p] == '0);
  end
endmodule

// File: rtl/opnd_fwd_ctrl.sv
`timescale 1ns/1ps
module opnd_fwd_ctrl
  import opnd_bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          mwb_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  output fwd_sel_e      sel_o
);
  logic exm_hit, mwb_hit;

  assign exm_hit = exm_we_i && (exm_rd_i != '0) && (exm_rd_i == src_i);
  assign mwb_hit = mwb_we_i && (mwb_rd_i != '0) && (mwb_rd_i == src_i);

  // younger producer first
  always_comb begin
    if (exm_hit)      sel_o = SEL_EXM;
    else if (mwb_hit) sel_o = SEL_MWB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/opnd_fwd_mux.sv
`timescale 1ns/1ps
module opnd_fwd_mux
  import opnd_bypass_pkg::*;
#(
  parameter int DW = 32
) (
  input  fwd_sel_e      sel_i,
  input  logic [DW-1:0] rf_i,
  input  logic [DW-1:0] exm_i,
  input  logic [DW-1:0] mwb_i,
  output logic [DW-1:0] opnd_o
);
  always_comb begin
    unique case (sel_i)
      SEL_EXM: opnd_o = exm_i;
      SEL_MWB: opnd_o = mwb_i;
      default: opnd_o = rf_i;
    endcase
  end
endmodule

// File: rtl/opnd_bypass_top.sv
`timescale 1ns/1ps
module opnd_bypass_top
  import opnd_bypass_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int NOPS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_a_i,
  input  logic [AW-1:0] rd_addr_b_i,
  output logic [DW-1:0] rd_data_a_o,
  output logic [DW-1:0] rd_data_b_o,
  input  logic          wb_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic [AW-1:0] ex_src_a_i,
  input  logic [AW-1:0] ex_src_b_i,
  input  logic [DW-1:0] ex_opnd_a_i,
  input  logic [DW-1:0] ex_opnd_b_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic [DW-1:0] exm_data_i,
  input  logic          mwb_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic [DW-1:0] mwb_data_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic [DW-1:0] fwd_a_o,
  output logic [DW-1:0] fwd_b_o
);
  logic [NOPS-1:0][AW-1:0] ra, src;
  logic [NOPS-1:0][DW-1:0] rdat, opnd_in, opnd_out;
  fwd_sel_e                sel [NOPS];

  assign ra      = {rd_addr_b_i, rd_addr_a_i};
  assign src     = {ex_src_b_i, ex_src_a_i};
  assign opnd_in = {ex_opnd_b_i, ex_opnd_a_i};

  opnd_regfile #(.NREGS(NREGS), .DW(DW), .NPORTS(NOPS)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wb_we_i),
    .wa_i   (wb_rd_i),
    .wd_i   (wb_data_i),
    .ra_i   (ra),
    .rd_o   (rdat)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    opnd_fwd_ctrl #(.AW(AW)) u_ctrl (
      .src_i    (src[k]),
      .exm_we_i (exm_we_i),
      .exm_rd_i (exm_rd_i),
      .mwb_we_i (mwb_we_i),
      .mwb_rd_i (mwb_rd_i),
      .sel_o    (sel[k])
    );
    opnd_fwd_mux #(.DW(DW)) u_mux (
      .sel_i  (sel[k]),
      .rf_i   (opnd_in[k]),
      .exm_i  (exm_data_i),
      .mwb_i  (mwb_data_i),
      .opnd_o (opnd_out[k])
    );

    // R5 R7
    exm_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exm_we_i && exm_rd_i != '0 && exm_rd_i == src[k]) |-> opnd_out[k] == exm_data_i);
    // R6
    mwb_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(exm_we_i && exm_rd_i == src[k]) && mwb_we_i && mwb_rd_i != '0 && mwb_rd_i == src[k])
        |-> opnd_out[k] == mwb_data_i);
    // R8
    no_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src[k] == '0) |-> (sel[k] == SEL_RF && opnd_out[k] == opnd_in[k]));
    // R7
    sel_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sel[k]));
  end

  assign rd_data_a_o = rdat[0];
  assign rd_data_b_o = rdat[1];
  assign sel_a_o     = sel[0];
  assign sel_b_o     = sel[1];
  assign fwd_a_o     = opnd_out[0];
  assign fwd_b_o     = opnd_out[1];
endmodule

// File: tb/opnd_bypass_top_tb_top.sv
`timescale 1ns/1ps
module opnd_bypass_top_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  rd_addr_a = 0, rd_addr_b = 0, wb_rd = 0, src_a = 0, src_b = 0, exm_rd = 0, mwb_rd = 0;
  logic        wb_we = 0, exm_we = 0, mwb_we = 0;
  logic [31:0] wb_data = 0, opnd_a = 0, opnd_b = 0, exm_data = 0, mwb_data = 0;
  logic [31:0] rd_data_a, rd_data_b, fwd_a, fwd_b;
  logic [1:0]  sel_a, sel_b;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  opnd_bypass_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_a_i(rd_addr_a), .rd_addr_b_i(rd_addr_b),
    .rd_data_a_o(rd_data_a), .rd_data_b_o(rd_data_b),
    .wb_we_i(wb_we), .wb_rd_i(wb_rd), .wb_data_i(wb_data),
    .ex_src_a_i(src_a), .ex_src_b_i(src_b),
    .ex_opnd_a_i(opnd_a), .ex_opnd_b_i(opnd_b),
    .exm_we_i(exm_we), .exm_rd_i(exm_rd), .exm_data_i(exm_data),
    .mwb_we_i(mwb_we), .mwb_rd_i(mwb_rd), .mwb_data_i(mwb_data),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(); @(negedge clk); #1; endtask

  task automatic idle();
    wb_we = 0; exm_we = 0; mwb_we = 0;
    exm_rd = 0; mwb_rd = 0; wb_rd = 0;
  endtask

  task automatic t_reset();
    rd_addr_a = 5'd5; rd_addr_b = 5'd31; src_a = 5'd4; src_b = 5'd6;
    opnd_a = 32'hA0A0_0001; opnd_b = 32'hB0B0_0002;
    settle();
    check("R1 rd a", rd_data_a, 0);
    check("R1 rd b", rd_data_b, 0);
    check("R8 sel a idle", {30'd0, sel_a}, 0);
    check("R8 fwd a idle", fwd_a, 32'hA0A0_0001);
  endtask

  task automatic t_rf_write();
    @(negedge clk); wb_we = 1; wb_rd = 5'd7; wb_data = 32'h1111_2222;
    @(negedge clk); wb_rd = 5'd0; wb_data = 32'hDEAD_BEEF;
    @(negedge clk); idle(); rd_addr_a = 5'd7; rd_addr_b = 5'd0;
    #1;
    check("R3 stored r7", rd_data_a, 32'h1111_2222);
    check("R2 r0 after write", rd_data_b, 0);
  endtask

  task automatic t_write_around();
    @(negedge clk); wb_we = 1; wb_rd = 5'd9; wb_data = 32'h0909_0909;
    rd_addr_a = 5'd9; rd_addr_b = 5'd10; #1;
    check("R4 same-cycle a", rd_data_a, 32'h0909_0909);
    check("R9 other port b", rd_data_b, 0);
    @(negedge clk); wb_we = 1; wb_rd = 5'd9; wb_data = 32'h5555_AAAA;
    rd_addr_a = 5'd7; rd_addr_b = 5'd9; #1;
    check("R4 same-cycle b", rd_data_b, 32'h5555_AAAA);
    check("R9 port a unaffected", rd_data_a, 32'h1111_2222);
    @(negedge clk); wb_we = 0; wb_rd = 5'd7; wb_data = 32'hFFFF_0000;
    #1;
    check("R4 we low keeps stored", rd_data_a, 32'h1111_2222);
    check("R3 r9 last write", rd_data_b, 32'h5555_AAAA);
    @(negedge clk); wb_we = 1; wb_rd = 5'd0; wb_data = 32'h1234_5678;
    rd_addr_a = 5'd0; #1;
    check("R2 no bypass to r0", rd_data_a, 0);
    @(negedge clk); idle();
  endtask

  task automatic t_exm();
    idle(); src_a = 5'd3; src_b = 5'd8; opnd_a = 32'h1; opnd_b = 32'h2;
    exm_we = 1; exm_rd = 5'd3; exm_data = 32'hE0E0_0003; settle();
    check("R5 sel a", {30'd0, sel_a}, 2);
    check("R5 fwd a", fwd_a, 32'hE0E0_0003);
    check("R9 sel b", {30'd0, sel_b}, 0);
    check("R9 fwd b", fwd_b, 32'h2);
  endtask

  task automatic t_mwb();
    idle(); src_a = 5'd11; src_b = 5'd11; opnd_a = 32'h3; opnd_b = 32'h4;
    exm_we = 1; exm_rd = 5'd12; exm_data = 32'hE;
    mwb_we = 1; mwb_rd = 5'd11; mwb_data = 32'hB0B0_0011; settle();
    check("R6 sel a", {30'd0, sel_a}, 1);
    check("R6 fwd a", fwd_a, 32'hB0B0_0011);
    check("R6 fwd b", fwd_b, 32'hB0B0_0011);
  endtask

  task automatic t_prio();
    idle(); src_a = 5'd14; src_b = 5'd15; opnd_a = 32'h5; opnd_b = 32'h6;
    exm_we = 1; exm_rd = 5'd14; exm_data = 32'hAAAA_0014;
    mwb_we = 1; mwb_rd = 5'd14; mwb_data = 32'hBBBB_0014; settle();
    check("R7 sel a", {30'd0, sel_a}, 2);
    check("R7 fwd a", fwd_a, 32'hAAAA_0014);
    check("R9 fwd b", fwd_b, 32'h6);
    exm_we = 0; settle();
    check("R7 exm disabled falls to mwb", fwd_a, 32'hBBBB_0014);
  endtask

  task automatic t_no_fwd();
    idle(); src_a = 5'd20; src_b = 5'd0; opnd_a = 32'h7; opnd_b = 32'h8;
    exm_we = 0; exm_rd = 5'd20; exm_data = 32'hDEAD;
    mwb_we = 1; mwb_rd = 5'd0; mwb_data = 32'hBEEF; settle();
    check("R8 we low sel a", {30'd0, sel_a}, 0);
    check("R8 we low fwd a", fwd_a, 32'h7);
    check("R8 dest zero fwd b", fwd_b, 32'h8);
    exm_we = 1; exm_rd = 5'd0; settle();
    check("R8 exm zero dest sel b", {30'd0, sel_b}, 0);
    check("R8 exm zero dest fwd b", fwd_b, 32'h8);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rf_write();
    t_write_around();
    t_exm();
    t_mwb();
    t_prio();
    t_no_fwd();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule